// File: doc/BRIEF.md
# Audio serial port clock master

This block drives a stereo serial audio link as the clock owner. From a single core clock it derives a bit clock and a left/right frame clock. It then sends two 24-bit two's-complement samples per frame, left and right, on one data line. A two-bit speed select sets the frame length in core clocks. An optional prescaler doubles every period. A format pin picks between left-justified alignment and I2S alignment.

The core clock `clk` runs at twice the master-clock rate, so one core cycle is one half-period of the master clock. With this, the fastest mode can produce a bit clock equal to the master clock from plain registers. Parallel samples arrive on two word inputs with a one-cycle load strobe. They are held until the next frame begins, then sent. If no new load arrives, the last words are repeated. Reset is synchronous and active high.

Top module: `aud_port_master`

## Requirements
- R1: With `mclk_div2` = 1, every bit-clock and frame-clock half-period is twice as long in `clk` cycles as with `mclk_div2` = 0.
- R2: With `mclk_div2` = 0, a bit-clock half-period lasts 4, 2 or 1 `clk` cycles for `speed_sel` 00, 01 or 10. A frame therefore lasts 512, 256 or 128 cycles (the master clock divided by 256, 128 or 64).
- R3: Every frame holds 64 bit-clock periods. The frame clock spends 32 of them at each level, and each bit starts with the bit clock low.
- R4: With `speed_sel` = 11, `mode_err_o` is 1 and `bclk_o`, `lrclk_o` and `sdata_o` are all 0. Once a valid code returns, `mode_err_o` drops and a fresh frame starts from its first bit.
- R5: Each channel's 24-bit word is sent MSB first. The left word goes in the first half-frame and the right word in the second.
- R6: `lrclk_o` and `sdata_o` change only on a falling edge of `bclk_o`.
- R7: Left-justified (`i2s_fmt` = 0): `lrclk_o` is 1 while the left word is sent, and each MSB is in the first bit after the frame-clock edge.
- R8: I2S (`i2s_fmt` = 1): `lrclk_o` is 0 while the left word is sent, and each MSB comes one bit period after the frame-clock edge.
- R9: The 8 bit positions after the 24 data bits of each 32-bit half-frame are driven 0.
- R10: Words loaded with `word_load` = 1 are first sent in the frame that begins after the load. Frames with no new load repeat the previous words.
- R11: While `rst` is 1, `bclk_o` and `sdata_o` are 0, `lrclk_o` is 1 in left-justified format and 0 in I2S format, and the stored words are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| speed_sel | input | 2 | 00 single, 01 double, 10 quad speed, 11 reserved |
| mclk_div2 | input | 1 | 1 halves the master clock before all other use |
| i2s_fmt | input | 1 | 0 left-justified, 1 I2S alignment |
| left_word | input | 24 | Left sample, two's complement |
| right_word | input | 24 | Right sample, two's complement |
| word_load | input | 1 | Strobe that captures both words |
| lrclk_o | output | 1 | Frame (left/right) clock |
| bclk_o | output | 1 | Bit clock |
| sdata_o | output | 1 | Serial data |
| mode_err_o | output | 1 | Reserved speed code selected |

## Verification
All clocks and data come from one phase counter, so any slip in that counter shows up at the ports within one bit-clock half-period. It appears as a bit clock of the wrong width, a frame-clock edge away from a falling bit-clock edge, or data bits out of place. A wrong sample-holding register only shows up at the next frame start: a stale or early word is visible from the first data bit of that frame. The bench rebuilds every cycle of four frames from the requirements for each speed, prescale and format setting. It compares all three outputs on every cycle, which catches both kinds of fault in the first frame where they occur.

// File: rtl/aspm_pkg.sv
package aspm_pkg;

    localparam int SAMPLE_BITS    = 24;
    localparam int SLOT_BITS      = 32;
    localparam int CHANNELS       = 2;
    localparam int BITS_PER_FRAME = SLOT_BITS * CHANNELS;
    localparam int HALVES         = 2 * BITS_PER_FRAME;
    localparam int PHASE_W        = $clog2(HALVES);
    localparam int BIT_W          = $clog2(BITS_PER_FRAME);
    localparam int POS_W          = $clog2(SLOT_BITS);
    localparam int MAX_HALF       = 8;
    localparam int SUB_W          = $clog2(MAX_HALF);
    localparam int HLEN_W         = SUB_W + 1;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic [SAMPLE_BITS-1:0] left;
        logic [SAMPLE_BITS-1:0] right;
    } stereo_t;

    typedef struct packed {
        logic             chan;
        logic [POS_W-1:0] pos;
    } slot_t;

    // core cycles per bit-clock half-period
    function automatic logic [HLEN_W-1:0] half_len(speed_e spd, logic pre);
        logic [HLEN_W-1:0] base;
        case (spd)
            SPD_SINGLE: base = HLEN_W'(4);
            SPD_DOUBLE: base = HLEN_W'(2);
            default:    base = HLEN_W'(1);
        endcase
        return pre ? (base << 1) : base;
    endfunction

    // bit number inside the frame -> channel and position in its slot
    function automatic slot_t slot_of(logic [BIT_W-1:0] b, logic i2s);
        logic [BIT_W-1:0] q;
        slot_t s;
        q      = i2s ? (b - BIT_W'(1)) : b;
        s.chan = q[BIT_W-1];
        s.pos  = q[POS_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/aspm_timebase.sv
module aspm_timebase
    import aspm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  speed_e             spd,
    input  logic               pre,
    output logic [PHASE_W-1:0] phase,
    output logic               frame_tick,
    output logic               halted
);

    logic [SUB_W-1:0]  sub;
    logic [HLEN_W-1:0] hlen;
    logic              last_sub;

    assign halted   = (spd == SPD_RSVD);
    assign hlen     = half_len(spd, pre);
    assign last_sub = ({1'b0, sub} >= (hlen - HLEN_W'(1)));

    assign frame_tick = !halted && last_sub && (phase == {PHASE_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || halted) begin
            sub   <= '0;
            phase <= '0;
        end else if (last_sub) begin
            sub   <= '0;
            phase <= phase + PHASE_W'(1);
        end else begin
            sub   <= sub + SUB_W'(1);
        end
    end

    // R1
    sub_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && !$past(halted) && $stable(hlen)) |-> ({1'b0, sub} < hlen));

endmodule

// File: rtl/aspm_shifter.sv
module aspm_shifter
    import aspm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  stereo_t            words_in,
    input  logic               frame_tick,
    input  logic [PHASE_W-1:0] phase,
    input  logic               i2s,
    output logic               sbit
);

    stereo_t pending;
    stereo_t active;
    slot_t   slot;
    logic [SAMPLE_BITS-1:0] chan_word [CHANNELS];
    logic [CHANNELS-1:0]    ch_bit;
    logic [POS_W-1:0]       idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (load)
                pending <= words_in;
            if (frame_tick)
                active <= pending;
        end
    end

    assign slot = slot_of(phase[PHASE_W-1:1], i2s);
    assign idx  = POS_W'(SAMPLE_BITS - 1) - slot.pos;

    assign chan_word[0] = active.left;
    assign chan_word[1] = active.right;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        assign ch_bit[c] = (int'(slot.pos) < SAMPLE_BITS) ? chan_word[c][idx] : 1'b0;
    end

    assign sbit = ch_bit[slot.chan];

    // R10
    hold_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_tick) |-> $stable(active));

endmodule

// File: rtl/aud_port_master.sv
module aud_port_master
    import aspm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             speed_sel,
    input  logic                   mclk_div2,
    input  logic                   i2s_fmt,
    input  logic [SAMPLE_BITS-1:0] left_word,
    input  logic [SAMPLE_BITS-1:0] right_word,
    input  logic                   word_load,
    output logic                   lrclk_o,
    output logic                   bclk_o,
    output logic                   sdata_o,
    output logic                   mode_err_o
);

    speed_e             spd;
    logic [PHASE_W-1:0] phase;
    logic               frame_tick;
    logic               halted;
    logic               sbit;
    stereo_t            words;

    assign spd         = speed_e'(speed_sel);
    assign words.left  = left_word;
    assign words.right = right_word;

    aspm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .spd        (spd),
        .pre        (mclk_div2),
        .phase      (phase),
        .frame_tick (frame_tick),
        .halted     (halted)
    );

    aspm_shifter u_sh (
        .clk        (clk),
        .rst        (rst),
        .load       (word_load),
        .words_in   (words),
        .frame_tick (frame_tick),
        .phase      (phase),
        .i2s        (i2s_fmt),
        .sbit       (sbit)
    );

    // low half of each bit first; upper frame bit selects the second half-frame
    assign bclk_o     = !halted && phase[0];
    assign lrclk_o    = !halted && (phase[PHASE_W-1] ^ !i2s_fmt);
    assign sdata_o    = !halted && sbit;
    assign mode_err_o = halted;

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> (!bclk_o && !lrclk_o && !sdata_o));

    // R6
    lr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrclk_o) && !mode_err_o && !$past(mode_err_o) && !$past(rst)
         && $stable(i2s_fmt)) |-> $fell(bclk_o));

    // R6
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdata_o) && !mode_err_o && !$past(mode_err_o) && !$past(rst)
         && $stable(i2s_fmt)) |-> $fell(bclk_o));

endmodule

// File: tb/sim_aud_port_master.sv
`timescale 1ns/1ps
module sim_aud_port_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  speed_sel = 2'b00;
    logic        mclk_div2 = 1'b0;
    logic        i2s_fmt = 1'b0;
    logic [23:0] left_word = '0;
    logic [23:0] right_word = '0;
    logic        word_load = 1'b0;
    logic        lrclk_o, bclk_o, sdata_o, mode_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aud_port_master u0 (
        .clk(clk), .rst(rst), .speed_sel(speed_sel), .mclk_div2(mclk_div2),
        .i2s_fmt(i2s_fmt), .left_word(left_word), .right_word(right_word),
        .word_load(word_load), .lrclk_o(lrclk_o), .bclk_o(bclk_o),
        .sdata_o(sdata_o), .mode_err_o(mode_err_o)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic        p;
        logic        f;
        logic [23:0] l1, r1, l2, r2;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 24'h800001, 24'h7FFFFE, 24'h123456, 24'hFEDCBA},
        '{2'd1, 1'b0, 1'b0, 24'hA5A5A5, 24'h5A5A5A, 24'hFFFFFF, 24'h000001},
        '{2'd2, 1'b0, 1'b0, 24'hC00003, 24'h3FFFFC, 24'h0F0F0F, 24'hF0F0F0},
        '{2'd0, 1'b1, 1'b0, 24'h000080, 24'h800000, 24'h7FFFFF, 24'h800000},
        '{2'd0, 1'b0, 1'b1, 24'h800001, 24'h7FFFFE, 24'h123456, 24'hFEDCBA},
        '{2'd1, 1'b1, 1'b1, 24'hA5A5A5, 24'h5A5A5A, 24'h000001, 24'hFFFFFF},
        '{2'd2, 1'b0, 1'b1, 24'hFFFFFF, 24'hFFFFFF, 24'h800000, 24'h000001},
        '{2'd2, 1'b1, 1'b1, 24'h3C3C3C, 24'hC3C3C3, 24'h00FF00, 24'hFF00FF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // expected outputs after k core edges since reset release
    task automatic model(input vec_t v, input int k, output bit eb, output bit el, output bit ed);
        int h, hx, fr, b, q, p;
        logic [23:0] w;
        h  = (v.m == 2'd0 ? 4 : v.m == 2'd1 ? 2 : 1) * (v.p ? 2 : 1);
        hx = (k / h) % 128;
        fr = (k / h) / 128;
        b  = hx / 2;
        eb = hx[0];
        el = v.f ? (b >= 32) : (b < 32);
        q  = v.f ? (b + 63) % 64 : b;
        p  = q % 32;
        if (fr == 0)      w = '0;
        else if (fr < 3)  w = (q >= 32) ? v.r1 : v.l1;
        else              w = (q >= 32) ? v.r2 : v.l2;
        ed = (p < 24) ? w[23 - p] : 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        word_load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_sim();
    end

    initial begin
        // R11 reset state, left-justified and I2S
        do_reset();
        check(bclk_o == 1'b0, "R11 reset bclk", bclk_o, 0);
        check(lrclk_o == 1'b1, "R11 reset lrclk LJ", lrclk_o, 1);
        check(sdata_o == 1'b0, "R11 reset sdata", sdata_o, 0);
        check(mode_err_o == 1'b0, "R11 reset mode_err", mode_err_o, 0);
        i2s_fmt = 1'b1;
        @(negedge clk);
        check(lrclk_o == 1'b0, "R11 reset lrclk I2S", lrclk_o, 0);

        // table walk: every cycle of four frames against the model
        for (int n = 0; n < NV; n++) begin
            vec_t v;
            int h, frame, eb_err, el_err, ed_err;
            bit eb, el, ed;
            v = VECS[n];
            speed_sel = v.m; mclk_div2 = v.p; i2s_fmt = v.f;
            do_reset();
            rst = 1'b0;
            h = (v.m == 2'd0 ? 4 : v.m == 2'd1 ? 2 : 1) * (v.p ? 2 : 1);
            frame = 128 * h;
            eb_err = 0; el_err = 0; ed_err = 0;
            for (int k = 0; k < 4 * frame; k++) begin
                model(v, k, eb, el, ed);
                if (bclk_o !== eb)  eb_err++;
                if (lrclk_o !== el) el_err++;
                if (sdata_o !== ed) ed_err++;
                word_load = 1'b0;
                if (k == 0) begin
                    left_word = v.l1; right_word = v.r1; word_load = 1'b1;
                end else if (k == 2 * frame + 10) begin
                    left_word = v.l2; right_word = v.r2; word_load = 1'b1;
                end
                @(negedge clk);
            end
            word_load = 1'b0;
            // R1 R2 R3: bit clock period per speed and prescale
            check(eb_err == 0, $sformatf("R1 R2 R3 vec%0d bclk mismatches", n), eb_err, 0);
            // R3 R6 R7 R8: frame clock level and edge placement
            check(el_err == 0, $sformatf("R3 R6 R7 R8 vec%0d lrclk mismatches", n), el_err, 0);
            // R5 R6 R7 R8 R9 R10: data order, alignment, padding, frame capture
            check(ed_err == 0, $sformatf("R5 R9 R10 vec%0d sdata mismatches", n), ed_err, 0);
        end

        // R4 reserved speed code
        speed_sel = 2'b00; mclk_div2 = 1'b0; i2s_fmt = 1'b0;
        do_reset();
        rst = 1'b0;
        left_word = 24'hFFFFFF; right_word = 24'hFFFFFF; word_load = 1'b1;
        repeat (600) @(negedge clk);
        word_load = 1'b0;
        repeat (7) @(negedge clk);
        speed_sel = 2'b11;
        repeat (5) @(negedge clk);
        check(mode_err_o == 1'b1, "R4 mode_err on code 11", mode_err_o, 1);
        check(bclk_o == 1'b0, "R4 bclk held", bclk_o, 0);
        check(lrclk_o == 1'b0, "R4 lrclk held", lrclk_o, 0);
        check(sdata_o == 1'b0, "R4 sdata held", sdata_o, 0);
        speed_sel = 2'b00;
        @(negedge clk);
        check(mode_err_o == 1'b0, "R4 mode_err cleared", mode_err_o, 0);
        check(lrclk_o == 1'b1 && bclk_o == 1'b0, "R4 restart at bit 0",
              {lrclk_o, bclk_o}, 2);
        check(sdata_o == 1'b1, "R4 R5 restart sends left MSB", sdata_o, 1);
        repeat (3) @(negedge clk);
        check(bclk_o == 1'b1, "R2 R4 bclk rises after 4 cycles", bclk_o, 1);

        finish_sim();
    end

endmodule